// File: doc/BRIEF.md
# Pin Pull-Resistor Configuration Sequencer

This block sets the pull-up and pull-down enables of a bank of pins from a 32-bit register bus. It supports two programming styles, and a build parameter picks one of them. In the strobed style, software writes a 2-bit pull code to one shared control register and waits for a setup time. It then raises the clock bit of each pin that should take the code, and finally clears the clock register. A pin's pull latch only takes the code when its clock bit rises after enough setup time has passed. In the field style, each pin has a 2-bit pull field, sixteen pins to a 32-bit word, and the pin outputs follow the fields directly.

The bus has a write strobe, a byte address, write data, and a read-data output that is decoded from the address with no wait states. The block drives one pull-up enable and one pull-down enable per pin. The analog resistors are outside this block.

Top module: `pull_cfg_seq`

## Requirements
- R1: After a synchronous active-low reset, every pull-up and pull-down enable is low and every register reads zero.
- R2: In strobed style the control register at byte address 0x94 stores only write-data bits [1:0] and reads back with bits [31:2] zero.
- R3: In strobed style the clock words at 0x98 (pins 0 to 31) and 0x9C (pins 32 upward) read back as written, except that bits with no pin behind them read zero.
- R4: Strobed-style codes decode as follows: 0 gives no pull, 1 gives pull-down, 2 gives pull-up, and 3 gives no pull.
- R5: A pin's strobed latch captures the current control code only when the write to the clock word takes that pin's bit from 0 to 1 and at least SETUP_CYCLES clock cycles have passed since the last control write (or since reset). A strobe any earlier is ignored and the pin keeps its previous pull.
- R6: Writing 1 to a clock bit that already holds 1 latches nothing.
- R7: Pins whose clock bit does not rise keep their pull. This holds when the control code changes, when the clock word is written to zero, and on any cycle without a bus write.
- R8: In field style, pin p's 2-bit field sits in the word at 0xE4 + 4*(p/16), at bits (p%16)*2+1:(p%16)*2. Code 0 gives none, 1 gives pull-up, 2 gives pull-down, and 3 gives none. Field bits with no pin behind them read zero.
- R9: LEGACY_STYLE=1 selects the strobed style and LEGACY_STYLE=0 selects the field style. The registers of the style not selected read zero, and writes to them have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pull_up_en | output | NUM_PINS | Per-pin pull-up enable |
| pull_dn_en | output | NUM_PINS | Per-pin pull-down enable |

## Verification
A setup counter that is wrong shows up as a strobe that is accepted or refused one cycle too early. The pin's enables then differ from the expected value on the first cycle after that clock-word write, so the bench probes the gate at exactly SETUP_CYCLES-1 and SETUP_CYCLES idle cycles. Faulty edge detection shows up as a pin that changes on a repeated 1 or on a cleared clock word. A faulty field decode or address map shows up at once, on the pin pair that has just been written or in the readback of that word.

// File: rtl/pull_cfg_pkg.sv
// Package: shared constants, code types and decode helpers for the pull
// configuration sequencer. Assumes an 8-bit byte address bus.
package pull_cfg_pkg;

    localparam int ADDR_W = 8;

    // Register byte offsets (software-visible map)
    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h94;
    localparam logic [ADDR_W-1:0] CLK_OFS  = 8'hA0 - 8'h08;
    localparam logic [ADDR_W-1:0] FLD_OFS  = 8'hE4;

    typedef enum logic [1:0] {
        LG_OFF  = 2'd0,
        LG_DOWN = 2'd1,
        LG_UP   = 2'd2,
        LG_RSVD = 2'd3
    } legacy_code_e;

    typedef enum logic [1:0] {
        FD_NONE = 2'd0,
        FD_UP   = 2'd1,
        FD_DOWN = 2'd2,
        FD_RSVD = 2'd3
    } field_code_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pull_t;

    // Decode a strobed-style code into pull enables
    function automatic pull_t decode_legacy(input logic [1:0] code);
        pull_t r;
        r.up = (legacy_code_e'(code) == LG_UP);
        r.dn = (legacy_code_e'(code) == LG_DOWN);
        return r;
    endfunction

    // Decode a field-style code into pull enables
    function automatic pull_t decode_field(input logic [1:0] code);
        pull_t r;
        r.up = (field_code_e'(code) == FD_UP);
        r.dn = (field_code_e'(code) == FD_DOWN);
        return r;
    endfunction

endpackage

// File: rtl/pull_setup_timer.sv
// Module: counts clock cycles since the last control-code write and
// saturates at SETUP_CYCLES; ready is high once that many cycles passed.
// Assumes SETUP_CYCLES >= 1. Reset counts as a fresh write.
module pull_setup_timer #(
    parameter int SETUP_CYCLES = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ready
);
    localparam int CNT_W = $clog2(SETUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETUP_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Restart on each control write, otherwise count up to the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q < LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = (cnt_q == LIMIT);

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    assert_ready_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !restart) |=> ready);

endmodule

// File: rtl/pull_legacy_bank.sv
// Module: strobed-style pull control. Holds the shared 2-bit code, the
// per-pin clock words and one code latch per pin. A latch loads the code
// on a 0->1 write of its clock bit once the setup timer is ready.
// Assumes one bus write per cycle at most.
module pull_legacy_bank
    import pull_cfg_pkg::*;
#(
    parameter int NUM_PINS     = 58,
    parameter int SETUP_CYCLES = 150
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [31:0]                   wdata,
    output logic [1:0]                    ctrl_o,
    output logic [((NUM_PINS+31)/32)*32-1:0] clk_bits_o,
    output logic [NUM_PINS-1:0]           up_o,
    output logic [NUM_PINS-1:0]           dn_o
);
    localparam int CLK_WORDS = (NUM_PINS + 31) / 32;
    localparam int CLK_BITS  = CLK_WORDS * 32;

    logic [1:0]            ctrl_q;
    logic                  ctrl_hit;
    logic                  setup_ok;
    logic [CLK_WORDS-1:0]  clk_hit;
    logic [CLK_BITS-1:0]   clk_q;
    logic [CLK_BITS-1:0]   pin_mask;
    logic [NUM_PINS-1:0]   strobe;
    logic [2*NUM_PINS-1:0] code_q;
    logic                  accept_any;

    assign ctrl_hit = we && (addr == CTRL_OFS);

    // Hold the shared control code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
        end else if (ctrl_hit) begin
            ctrl_q <= wdata[1:0];
        end
    end

    pull_setup_timer #(
        .SETUP_CYCLES (SETUP_CYCLES)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_hit),
        .ready   (setup_ok)
    );

    genvar b, w, p;
    for (b = 0; b < CLK_BITS; b++) begin : g_mask
        assign pin_mask[b] = (b < NUM_PINS);
    end

    for (w = 0; w < CLK_WORDS; w++) begin : g_clk_word
        assign clk_hit[w] = we && (addr == CLK_OFS + ADDR_W'(4 * w));

        // Store one clock word, dropping bits without a pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clk_q[w*32 +: 32] <= '0;
            end else if (clk_hit[w]) begin
                clk_q[w*32 +: 32] <= wdata & pin_mask[w*32 +: 32];
            end
        end
    end

    for (p = 0; p < NUM_PINS; p++) begin : g_pin
        pull_t pin_pull;

        assign strobe[p] = clk_hit[p/32] & wdata[p%32] & ~clk_q[p];

        // Capture the shared code on an accepted rising strobe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[2*p +: 2] <= LG_OFF;
            end else if (strobe[p] && setup_ok) begin
                code_q[2*p +: 2] <= ctrl_q;
            end
        end

        assign pin_pull = decode_legacy(code_q[2*p +: 2]);
        assign up_o[p]  = pin_pull.up;
        assign dn_o[p]  = pin_pull.dn;
    end

    assign accept_any = (|strobe) && setup_ok;
    assign ctrl_o     = ctrl_q;
    assign clk_bits_o = clk_q;

    assert_latch_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> $past(accept_any));

    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_hit |=> $stable(ctrl_q));

endmodule

// File: rtl/pull_field_bank.sv
// Module: field-style pull control. One 2-bit field per pin, sixteen
// pins per 32-bit word; the pin outputs decode the fields directly.
// Assumes one bus write per cycle at most.
module pull_field_bank
    import pull_cfg_pkg::*;
#(
    parameter int NUM_PINS = 58
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [31:0]                      wdata,
    output logic [((NUM_PINS+15)/16)*32-1:0] fld_o,
    output logic [NUM_PINS-1:0]              up_o,
    output logic [NUM_PINS-1:0]              dn_o
);
    localparam int FLD_WORDS = (NUM_PINS + 15) / 16;
    localparam int FLD_BITS  = FLD_WORDS * 32;

    logic [FLD_BITS-1:0]  fld_q;
    logic [FLD_BITS-1:0]  fld_mask;
    logic [FLD_WORDS-1:0] fld_hit;

    genvar b, w, p;
    for (b = 0; b < FLD_BITS; b++) begin : g_mask
        assign fld_mask[b] = ((b / 2) < NUM_PINS);
    end

    for (w = 0; w < FLD_WORDS; w++) begin : g_word
        assign fld_hit[w] = we && (addr == FLD_OFS + ADDR_W'(4 * w));

        // Store one field word, dropping fields without a pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_q[w*32 +: 32] <= '0;
            end else if (fld_hit[w]) begin
                fld_q[w*32 +: 32] <= wdata & fld_mask[w*32 +: 32];
            end
        end
    end

    for (p = 0; p < NUM_PINS; p++) begin : g_pin
        pull_t pin_pull;
        assign pin_pull = decode_field(fld_q[2*p +: 2]);
        assign up_o[p]  = pin_pull.up;
        assign dn_o[p]  = pin_pull.dn;
    end

    assign fld_o = fld_q;

    assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|fld_hit) |=> $stable(fld_q));

endmodule

// File: rtl/pull_cfg_seq.sv
// Module: top of the pull configuration sequencer. Decodes the register
// bus, instantiates the style chosen by LEGACY_STYLE and returns zero for
// the registers of the other style. Assumes the register map fits in an
// 8-bit byte address (NUM_PINS up to 64 with the default offsets).
module pull_cfg_seq
    import pull_cfg_pkg::*;
#(
    parameter int NUM_PINS     = 58,
    parameter int SETUP_CYCLES = 150,
    parameter bit LEGACY_STYLE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] pull_up_en,
    output logic [NUM_PINS-1:0] pull_dn_en
);
    localparam int CLK_WORDS = (NUM_PINS + 31) / 32;
    localparam int FLD_WORDS = (NUM_PINS + 15) / 16;

    logic [1:0]              ctrl_view;
    logic [CLK_WORDS*32-1:0] clk_view;
    logic [FLD_WORDS*32-1:0] fld_view;

    if (LEGACY_STYLE) begin : g_legacy
        pull_legacy_bank #(
            .NUM_PINS     (NUM_PINS),
            .SETUP_CYCLES (SETUP_CYCLES)
        ) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .we         (bus_we),
            .addr       (bus_addr),
            .wdata      (bus_wdata),
            .ctrl_o     (ctrl_view),
            .clk_bits_o (clk_view),
            .up_o       (pull_up_en),
            .dn_o       (pull_dn_en)
        );
        assign fld_view = '0;
    end else begin : g_field
        pull_field_bank #(
            .NUM_PINS (NUM_PINS)
        ) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_we),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .fld_o (fld_view),
            .up_o  (pull_up_en),
            .dn_o  (pull_dn_en)
        );
        assign ctrl_view = '0;
        assign clk_view  = '0;
    end

    // Return the register selected by the address, zero when unmapped
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFS) begin
            bus_rdata = {30'b0, ctrl_view};
        end
        for (int w = 0; w < CLK_WORDS; w++) begin
            if (bus_addr == CLK_OFS + ADDR_W'(4 * w)) begin
                bus_rdata = clk_view[w*32 +: 32];
            end
        end
        for (int w = 0; w < FLD_WORDS; w++) begin
            if (bus_addr == FLD_OFS + ADDR_W'(4 * w)) begin
                bus_rdata = fld_view[w*32 +: 32];
            end
        end
    end

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pull_up_en) && $stable(pull_dn_en)));

    if (LEGACY_STYLE) begin : g_chk_legacy
        assert_field_unseen_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr >= FLD_OFS) |-> (bus_rdata == '0));
    end else begin : g_chk_field
        assert_strobe_unseen_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr < FLD_OFS) |-> (bus_rdata == '0));
    end

endmodule

// File: tb/test_pull_cfg_seq.sv
// Bench: a vector table drives the strobed-style instance, then directed
// tests cover the field-style instance and a reset in mid-run.
module test_pull_cfg_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 58;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_PIN = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;   // byte address, or pin index for OP_PIN
        logic [31:0] data;   // write data / expected read / {up,dn}
        logic [7:0]  gap;    // idle cycles after a write
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{OP_WR,  8'h94, 32'hFFFF_FFFE, 8'd150, 8'd2},  // R2 code up
        '{OP_RD,  8'h94, 32'h0000_0002, 8'd0,   8'd2},  // R2 low bits only
        '{OP_WR,  8'h98, 32'h0000_0005, 8'd0,   8'd5},  // R5 accepted strobe
        '{OP_PIN, 8'd0,  32'd2,         8'd0,   8'd4},  // R4 up
        '{OP_PIN, 8'd2,  32'd2,         8'd0,   8'd4},
        '{OP_PIN, 8'd1,  32'd0,         8'd0,   8'd7},  // R7 not strobed
        '{OP_RD,  8'h98, 32'h0000_0005, 8'd0,   8'd3},  // R3 readback
        '{OP_WR,  8'h98, 32'h0000_0000, 8'd0,   8'd7},  // R7 clear clock word
        '{OP_PIN, 8'd0,  32'd2,         8'd0,   8'd7},
        '{OP_WR,  8'h94, 32'h0000_0001, 8'd149, 8'd5},  // R5 one cycle short
        '{OP_WR,  8'h98, 32'h0000_0002, 8'd0,   8'd5},
        '{OP_PIN, 8'd1,  32'd0,         8'd0,   8'd5},
        '{OP_RD,  8'h98, 32'h0000_0002, 8'd0,   8'd3},
        '{OP_WR,  8'h98, 32'h0000_0002, 8'd0,   8'd6},  // R6 bit already set
        '{OP_PIN, 8'd1,  32'd0,         8'd0,   8'd6},
        '{OP_WR,  8'h98, 32'h0000_0000, 8'd0,   8'd5},
        '{OP_WR,  8'h98, 32'h0000_0002, 8'd0,   8'd5},  // R5 fresh rise
        '{OP_PIN, 8'd1,  32'd1,         8'd0,   8'd4},  // R4 down
        '{OP_PIN, 8'd0,  32'd2,         8'd0,   8'd7},  // R7 code change kept
        '{OP_WR,  8'h9C, 32'hFFFF_FFFF, 8'd0,   8'd3},
        '{OP_RD,  8'h9C, 32'h03FF_FFFF, 8'd0,   8'd3},  // R3 padding bits
        '{OP_PIN, 8'd57, 32'd1,         8'd0,   8'd5},
        '{OP_PIN, 8'd40, 32'd1,         8'd0,   8'd5},
        '{OP_WR,  8'h94, 32'h0000_0003, 8'd150, 8'd4},
        '{OP_WR,  8'h98, 32'h0000_0000, 8'd0,   8'd4},
        '{OP_WR,  8'h98, 32'h0000_0001, 8'd0,   8'd4},
        '{OP_PIN, 8'd0,  32'd0,         8'd0,   8'd4},  // R4 code 3 is off
        '{OP_PIN, 8'd2,  32'd2,         8'd0,   8'd7},
        '{OP_WR,  8'h94, 32'h0000_0000, 8'd150, 8'd4},
        '{OP_WR,  8'h9C, 32'h0000_0000, 8'd0,   8'd4},
        '{OP_WR,  8'h9C, 32'h0000_0001, 8'd0,   8'd4},
        '{OP_PIN, 8'd32, 32'd0,         8'd0,   8'd4},  // R4 code 0 is off
        '{OP_PIN, 8'd33, 32'd1,         8'd0,   8'd7},
        '{OP_WR,  8'hE4, 32'h5555_5555, 8'd0,   8'd9},  // R9 field regs absent
        '{OP_RD,  8'hE4, 32'h0000_0000, 8'd0,   8'd9},
        '{OP_PIN, 8'd3,  32'd0,         8'd0,   8'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we_a = 1'b0;
    logic          we_b = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata_a, rdata_b;
    logic [NP-1:0] up_a, dn_a, up_b, dn_b;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pull_cfg_seq #(.NUM_PINS(NP), .SETUP_CYCLES(150), .LEGACY_STYLE(1'b1)) i_pull_cfg_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(we_a), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a),
        .pull_up_en(up_a), .pull_dn_en(dn_a)
    );

    pull_cfg_seq #(.NUM_PINS(NP), .SETUP_CYCLES(150), .LEGACY_STYLE(1'b0)) i_pull_cfg_seq_fld (
        .clk(clk), .rst_n(rst_n), .bus_we(we_b), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_b),
        .pull_up_en(up_b), .pull_dn_en(dn_b)
    );

    task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit side_b, input logic [7:0] a, input logic [31:0] d, input int gap);
        addr  = a;
        wdata = d;
        if (side_b) we_b = 1'b1; else we_a = 1'b1;
        @(negedge clk);
        we_a = 1'b0;
        we_b = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic rd(input bit side_b, input logic [7:0] a, input int req, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, side_b ? rdata_b : rdata_a, exp);
    endtask

    task automatic pin(input bit side_b, input int p, input int req, input logic [1:0] exp);
        #1;
        if (side_b) chk(req, {up_b[p], dn_b[p]}, exp);
        else        chk(req, {up_a[p], dn_a[p]}, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of both styles
        chk(1, {6'b0, up_a, dn_a[57:52]} | {6'b0, dn_a}, 64'd0);
        chk(1, {6'b0, up_b} | {6'b0, dn_b}, 64'd0);
        rd(1'b0, 8'h94, 1, 32'd0);
        rd(1'b0, 8'h98, 1, 32'd0);
        rd(1'b1, 8'hE4, 1, 32'd0);

        // Table walk on the strobed-style instance
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR:   wr(1'b0, VECS[i].addr, VECS[i].data, int'(VECS[i].gap));
                OP_RD:   rd(1'b0, VECS[i].addr, int'(VECS[i].req), VECS[i].data);
                default: pin(1'b0, int'(VECS[i].addr), int'(VECS[i].req), VECS[i].data[1:0]);
            endcase
        end

        // R8: field placement and encoding on the field-style instance
        wr(1'b1, 8'hE8, 32'h0000_0009, 0);
        pin(1'b1, 16, 8, 2'b10);
        pin(1'b1, 17, 8, 2'b01);
        pin(1'b1, 18, 8, 2'b00);
        wr(1'b1, 8'hF0, 32'hFFFF_FFFF, 0);
        rd(1'b1, 8'hF0, 8, 32'h000F_FFFF);
        pin(1'b1, 57, 8, 2'b00);
        pin(1'b1, 48, 8, 2'b00);
        wr(1'b1, 8'hE4, 32'h0000_0024, 0);
        pin(1'b1, 0, 8, 2'b00);
        pin(1'b1, 1, 8, 2'b10);
        pin(1'b1, 2, 8, 2'b01);

        // R9: strobed registers absent in field style
        wr(1'b1, 8'h94, 32'h0000_0002, 0);
        rd(1'b1, 8'h94, 9, 32'd0);
        wr(1'b1, 8'h98, 32'hFFFF_FFFF, 0);
        rd(1'b1, 8'h98, 9, 32'd0);
        pin(1'b1, 5, 9, 2'b00);
        pin(1'b1, 1, 9, 2'b10);

        // R1: reset in mid-run clears latches and registers
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pin(1'b0, 2, 1, 2'b00);
        pin(1'b0, 1, 1, 2'b00);
        rd(1'b0, 8'h9C, 1, 32'd0);
        pin(1'b1, 1, 1, 2'b00);
        rd(1'b1, 8'hE8, 1, 32'd0);

        finish_run();
    end

endmodule